// File: doc/BRIEF.md
# Conversion Start and Busy Sequencer

This block times every conversion of a sampling converter. An active-low start request is brought into the clock domain, and its falling edge places the sample stage in hold and begins a conversion. Busy stays high for a fixed number of clock cycles. When the conversion ends, the result is captured, busy drops, and a one-cycle data-ready strobe marks that edge for downstream logic. An acquisition window of fixed length follows before another request is accepted.

A synchronous abort input cancels the work in progress and leaves the old result in place. A power-down input lets the conversion in progress finish and then refuses new ones for as long as it is held. In impulse mode (impulse select high, warp select low), a start request that is still held low when acquisition ends begins the next conversion at once, with no new edge needed. The analog front end and the bit-decision core are outside this block. The value captured as the result comes from an input port.

Top module: `conv_sequencer`

## Requirements
- R1: While rst_n is low, busy_o, hold_o and data_ready_o are 0 and result_o is all zeros.
- R2: start_n_i is active low. If edge 1 is the first rising clock edge at which start_n_i is seen low after being high, and the block is idle, busy_o and hold_o are still 0 after edge 2 and are 1 after edge 3.
- R3: A conversion that is not aborted keeps busy_o high for exactly CONV_CYCLES clock cycles. At the edge where busy_o falls, result_o loads sample_i.
- R4: data_ready_o is high for exactly one cycle, the first cycle in which busy_o is low after a completed conversion, and at no other time.
- R5: Outside impulse mode, a falling edge of start_n_i that reaches the edge detector while busy_o is high, or within the ACQ_CYCLES cycles that follow, starts no conversion.
- R6: abort_i high at a rising edge makes busy_o 0 from that edge on. No data_ready_o pulse follows and result_o keeps its previous value.
- R7: pwr_down_i asserted during a conversion lets it finish normally with its result. While pwr_down_i is high and busy_o is low, no conversion starts.
- R8: With impulse_i=1 and warp_i=0, if start_n_i is still low when acquisition ends, busy_o rises again exactly ACQ_CYCLES cycles after it fell. Once start_n_i is back high before acquisition ends, no further conversion follows.
- R9: With warp_i=1, or with impulse_i=0, a start_n_i held low through acquisition does not start another conversion.
- R10: result_o changes only at the edge that raises data_ready_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_n_i | input | 1 | Active-low start request, asynchronous to clk; its falling edge starts a conversion |
| abort_i | input | 1 | Synchronous abort; when high, the current conversion is cancelled |
| pwr_down_i | input | 1 | Power-down request; blocks new conversions after the current one |
| impulse_i | input | 1 | Impulse mode select |
| warp_i | input | 1 | Warp select; when high, impulse retriggering is disabled |
| sample_i | input | DATA_W | Stand-in conversion value, captured when a conversion completes |
| hold_o | output | 1 | Sample stage hold control, high while converting |
| busy_o | output | 1 | High while a conversion is in progress |
| data_ready_o | output | 1 | One-cycle strobe in the first cycle after busy falls on completion |
| result_o | output | DATA_W | Last completed conversion result |

## Verification
The assertions assume that abort_i, pwr_down_i, impulse_i, warp_i and sample_i are synchronous to clk, and that rst_n is applied from time zero. Only start_n_i may arrive at any time. The bench changes every input on the falling clock edge, holds each start_n_i level for at least two clock cycles so that the synchronizer sees it, and changes the mode selects only while the block is idle. Under these conditions, busy length, strobe placement, abort effect and power-down blocking each follow from the ports alone.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CONVERT = 2'd1,
    ST_ACQUIRE = 2'd2,
    ST_PWRDN   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/conv_start_detect.sv
module conv_start_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_n_i,
  output logic start_fall_o,
  output logic start_low_o
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q;
  logic         last_q;

  // Synchronizer chain, idle level high so reset never fakes an edge
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= start_n_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= sync_q[TOP];
  end

  assign start_fall_o = last_q & ~sync_q[TOP];
  assign start_low_o  = ~sync_q[TOP];

endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign done_o = (cnt_q == '0);
  assign cnt_en = load_i | ~done_o;

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/conv_fsm.sv
module conv_fsm
  import conv_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 28,
  parameter int ACQ_CYCLES  = 8,
  parameter int CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_fall_i,
  input  logic             start_low_i,
  input  logic             abort_i,
  input  logic             pwr_down_i,
  input  logic             impulse_i,
  input  logic             warp_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             complete_o,
  output seq_state_e       state_o
);

  localparam logic [CNT_W-1:0] CONV_LOAD = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] ACQ_LOAD  = CNT_W'(ACQ_CYCLES - 1);

  seq_state_e state_q, state_d;
  logic       retrigger_en;

  assign retrigger_en = impulse_i & ~warp_i;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = CONV_LOAD;
    complete_o = 1'b0;
    if (abort_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pwr_down_i) begin
            state_d = ST_PWRDN;
          end else if (start_fall_i) begin
            state_d    = ST_CONVERT;
            tmr_load_o = 1'b1;
            tmr_val_o  = CONV_LOAD;
          end
        end
        ST_CONVERT: begin
          if (tmr_done_i) begin
            complete_o = 1'b1;
            if (pwr_down_i) begin
              state_d = ST_PWRDN;
            end else begin
              state_d    = ST_ACQUIRE;
              tmr_load_o = 1'b1;
              tmr_val_o  = ACQ_LOAD;
            end
          end
        end
        ST_ACQUIRE: begin
          if (pwr_down_i) begin
            state_d = ST_PWRDN;
          end else if (tmr_done_i) begin
            if (retrigger_en && start_low_i) begin
              state_d    = ST_CONVERT;
              tmr_load_o = 1'b1;
              tmr_val_o  = CONV_LOAD;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_PWRDN: begin
          if (!pwr_down_i) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/conv_result_reg.sv
module conv_result_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              complete_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ready_o
);

  logic [DATA_W-1:0] result_q;
  logic              ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          result_q <= '0;
    else if (complete_i) result_q <= sample_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= complete_i;
  end

  assign result_o = result_q;
  assign ready_o  = ready_q;

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 28,
  parameter int ACQ_CYCLES  = 8,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n_i,
  input  logic              abort_i,
  input  logic              pwr_down_i,
  input  logic              impulse_i,
  input  logic              warp_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              hold_o,
  output logic              busy_o,
  output logic              data_ready_o,
  output logic [DATA_W-1:0] result_o
);

  localparam int MAX_CYC = (CONV_CYCLES > ACQ_CYCLES) ? CONV_CYCLES : ACQ_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             start_fall;
  logic             start_low;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             complete;
  seq_state_e       state;

  conv_start_detect #(.SYNC_STAGES(SYNC_STAGES)) u_start (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_n_i    (start_n_i),
    .start_fall_o (start_fall),
    .start_low_o  (start_low)
  );

  conv_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  conv_fsm #(
    .CONV_CYCLES (CONV_CYCLES),
    .ACQ_CYCLES  (ACQ_CYCLES),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_fall_i (start_fall),
    .start_low_i  (start_low),
    .abort_i      (abort_i),
    .pwr_down_i   (pwr_down_i),
    .impulse_i    (impulse_i),
    .warp_i       (warp_i),
    .tmr_done_i   (tmr_done),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .complete_o   (complete),
    .state_o      (state)
  );

  conv_result_reg #(.DATA_W(DATA_W)) u_result (
    .clk        (clk),
    .rst_n      (rst_n),
    .complete_i (complete),
    .sample_i   (sample_i),
    .result_o   (result_o),
    .ready_o    (data_ready_o)
  );

  assign busy_o = (state == ST_CONVERT);
  assign hold_o = (state == ST_CONVERT);

endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int CONV_CYCLES = 28,
  parameter int DATA_W      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abort_i,
  input logic              pwr_down_i,
  input logic              busy_o,
  input logic              data_ready_o,
  input logic [DATA_W-1:0] result_o
);

  localparam int RUN_W = $clog2(CONV_CYCLES + 2) + 1;

  logic [RUN_W-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_run <= '0;
    else if (busy_o) busy_run <= busy_run + RUN_W'(1);
    else             busy_run <= '0;
  end

  // R3: busy never lasts longer than the conversion time
  a_r3_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (busy_run < RUN_W'(CONV_CYCLES)));

  // R4: strobe only right after a full-length busy period
  a_r4_ready_after_full_busy: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready_o |-> ($past(busy_o) && !busy_o && ($past(busy_run) == RUN_W'(CONV_CYCLES - 1))));

  // R4: strobe lasts a single cycle
  a_r4_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready_o |=> !data_ready_o);

  // R6: abort clears busy and suppresses the strobe
  a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_o && !data_ready_o));

  // R7: no new conversion while powered down and idle
  a_r7_pwrdn_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down_i && !busy_o) |=> !busy_o);

  // R10: result moves only with the strobe
  a_r10_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready_o |-> $stable(result_o));

endmodule

bind conv_sequencer conv_sequencer_chk #(
  .CONV_CYCLES (CONV_CYCLES),
  .DATA_W      (DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .abort_i      (abort_i),
  .pwr_down_i   (pwr_down_i),
  .busy_o       (busy_o),
  .data_ready_o (data_ready_o),
  .result_o     (result_o)
);

// File: tb/tb_conv_sequencer.sv
`timescale 1ns/1ps
module tb_conv_sequencer;

  localparam int CONV   = 28;
  localparam int ACQ    = 8;
  localparam int DW     = 16;

  logic          clk;
  logic          rst_n;
  logic          start_n;
  logic          abort;
  logic          pwr_down;
  logic          impulse;
  logic          warp;
  logic [DW-1:0] sample;
  logic          hold;
  logic          busy;
  logic          ready;
  logic [DW-1:0] result;

  int checks;
  int errors;
  int ready_cnt;
  int rise_cnt;
  int busy_len;
  int low_len;
  bit gap_chk;
  bit after_done;
  bit prev_busy;
  bit prev_ready;
  bit done_flag;
  logic [DW-1:0] exp_q[$];

  conv_sequencer #(
    .CONV_CYCLES (CONV),
    .ACQ_CYCLES  (ACQ),
    .DATA_W      (DW),
    .SYNC_STAGES (2)
  ) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_n_i    (start_n),
    .abort_i      (abort),
    .pwr_down_i   (pwr_down),
    .impulse_i    (impulse),
    .warp_i       (warp),
    .sample_i     (sample),
    .hold_o       (hold),
    .busy_o       (busy),
    .data_ready_o (ready),
    .result_o     (result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!ready && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(ready, req, "timeout waiting for data_ready", ready, 1);
  endtask

  // Driver: pushes the expected result, then issues the start edge
  task automatic start_conv(input logic [DW-1:0] val, input bit expect_result);
    sample = val;
    if (expect_result) exp_q.push_back(val);
    start_n = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !prev_busy) begin
        rise_cnt++;
        if (gap_chk && after_done)
          chk(low_len == ACQ, "R8", "acquisition gap before retrigger", low_len, ACQ);
        after_done = 1'b0;
      end
      if (busy) begin
        busy_len++;
        low_len = 0;
      end else begin
        low_len++;
      end
      if (ready) begin
        ready_cnt++;
        after_done = 1'b1;
        chk(busy_len == CONV, "R3", "busy length", busy_len, CONV);
        chk(!busy, "R4", "busy low during strobe", busy, 0);
        chk(!prev_ready, "R4", "strobe longer than one cycle", prev_ready, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected result strobe", result, 0);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(result == e, "R3", "result value", result, e);
        end
      end
      if (!busy) busy_len = 0;
      prev_busy  = busy;
      prev_ready = ready;
    end
  end

  initial begin
    #1000000;
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0;
    int d0;
    checks = 0; errors = 0; ready_cnt = 0; rise_cnt = 0;
    busy_len = 0; low_len = 0; gap_chk = 0; after_done = 0;
    prev_busy = 0; prev_ready = 0; done_flag = 0;
    rst_n = 1'b0; start_n = 1'b1; abort = 1'b0; pwr_down = 1'b0;
    impulse = 1'b0; warp = 1'b0; sample = '0;
    cyc(3);
    // R1: reset state
    chk(!busy && !hold, "R1", "busy/hold in reset", {busy, hold}, 0);
    chk(!ready, "R1", "data_ready in reset", ready, 0);
    chk(result == '0, "R1", "result in reset", result, 0);
    rst_n = 1'b1;
    cyc(3);

    // R2 / R3 / R4: single conversion
    start_conv(16'hA5C3, 1'b1);
    cyc(2);
    chk(!busy && !hold, "R2", "busy before third edge", busy, 0);
    cyc(1);
    chk(busy && hold, "R2", "busy/hold after third edge", {busy, hold}, 2'b11);
    wait_ready("R3");
    chk(result == 16'hA5C3, "R3", "result after completion", result, 16'hA5C3);
    cyc(1);
    chk(!ready, "R4", "strobe gone next cycle", ready, 0);
    start_n = 1'b1;
    cyc(ACQ + 5);

    // R5: edges during busy and during acquisition are ignored
    r0 = rise_cnt;
    start_conv(16'h1234, 1'b1);
    cyc(10);
    start_n = 1'b1;
    cyc(5);
    start_n = 1'b0;
    wait_ready("R5");
    start_n = 1'b1;
    cyc(2);
    start_n = 1'b0;
    cyc(40);
    chk(rise_cnt == r0 + 1, "R5", "conversions started", rise_cnt - r0, 1);
    chk(!busy, "R5", "busy after ignored edges", busy, 0);
    start_n = 1'b1;
    cyc(5);

    // R7: power-down during a conversion, then blocking
    r0 = rise_cnt;
    start_conv(16'hBEEF, 1'b1);
    cyc(10);
    pwr_down = 1'b1;
    wait_ready("R7");
    chk(result == 16'hBEEF, "R7", "conversion finished under power-down", result, 16'hBEEF);
    start_n = 1'b1;
    cyc(3);
    start_n = 1'b0;
    cyc(20);
    chk(rise_cnt == r0 + 1, "R7", "no start while powered down", rise_cnt - r0, 1);
    pwr_down = 1'b0;
    start_n = 1'b1;
    cyc(5);
    start_conv(16'h0F0F, 1'b1);
    wait_ready("R7");
    chk(result == 16'h0F0F, "R7", "conversion after power-up", result, 16'h0F0F);
    start_n = 1'b1;
    cyc(ACQ + 4);

    // R6: abort
    r0 = rise_cnt;
    d0 = ready_cnt;
    start_conv(16'h7777, 1'b0);
    cyc(10);
    abort = 1'b1;
    cyc(1);
    chk(!busy, "R6", "busy after abort", busy, 0);
    abort = 1'b0;
    cyc(CONV + 10);
    chk(ready_cnt == d0, "R6", "strobe after abort", ready_cnt - d0, 0);
    chk(result == 16'h0F0F, "R6", "result kept after abort (R10)", result, 16'h0F0F);
    start_n = 1'b1;
    cyc(5);

    // R8: impulse retrigger
    impulse = 1'b1; warp = 1'b0;
    cyc(2);
    r0 = rise_cnt;
    gap_chk = 1'b1;
    start_conv(16'h3C3C, 1'b1);
    exp_q.push_back(16'h3C3C);
    exp_q.push_back(16'h3C3C);
    for (int k = 0; k < 3; k++) begin
      wait_ready("R8");
      if (k < 2) cyc(1);
    end
    start_n = 1'b1;
    cyc(40);
    chk(rise_cnt == r0 + 3, "R8", "retriggered conversions", rise_cnt - r0, 3);
    gap_chk = 1'b0;

    // R9: warp high blocks retrigger
    warp = 1'b1;
    cyc(2);
    r0 = rise_cnt;
    start_conv(16'h5A5A, 1'b1);
    wait_ready("R9");
    cyc(ACQ + 30);
    chk(rise_cnt == r0 + 1, "R9", "warp mode retrigger", rise_cnt - r0, 1);
    start_n = 1'b1;
    cyc(5);

    // R9: impulse off blocks retrigger
    impulse = 1'b0; warp = 1'b0;
    cyc(2);
    r0 = rise_cnt;
    start_conv(16'hC001, 1'b1);
    wait_ready("R9");
    cyc(ACQ + 30);
    chk(rise_cnt == r0 + 1, "R9", "normal mode retrigger", rise_cnt - r0, 1);
    start_n = 1'b1;
    cyc(5);

    // R7: power-down while idle blocks an edge
    r0 = rise_cnt;
    pwr_down = 1'b1;
    cyc(3);
    start_n = 1'b0;
    cyc(20);
    chk(rise_cnt == r0 && !busy, "R7", "idle power-down start", rise_cnt - r0, 0);
    pwr_down = 1'b0;
    start_n = 1'b1;
    cyc(5);

    chk(exp_q.size() == 0, "R3", "outstanding expected results", exp_q.size(), 0);
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule